// File: doc/BRIEF.md
# Password-Locked Checksummed Register Bank

The block holds sixteen 8-bit configuration registers split into four groups of four. Each group has a checksum register that the host fills with the modulo-256 sum it expects the group to hold. Groups 2 and 3, and their checksum registers, are guarded. A write to them takes effect only after a two-byte key has been written to the key register. Any further key write closes the guarded space again. A guarded write made while the space is closed is dropped, and it raises a sticky violation flag.

A background scrubber runs all the time. It spends one scan window of `SCAN_PERIOD` cycles on each group in turn. At the end of the window it adds up the group's registers and compares the result with the stored checksum. A difference sets the group's mismatch bit, which the host can read in the status register. If the group was written at any point during the window, the result of that window is thrown away. This stops an update that is half done from being reported as corruption.

Top module: `lockable_csum_regbank`

## Requirements
- R1: An active-low asynchronous reset clears all data and checksum registers to 0, closes the guarded space, clears every mismatch bit and clears the violation flag.
- R2: Address map, where `rdata` is combinational on `addr` in the same cycle. Addresses 0x00–0x0F hold data register `addr[3:0]` of group `addr[3:2]`. Addresses 0x10–0x13 hold the checksum of group `addr[1:0]`. Address 0x14 is the key register and reads {7'b0, unlocked}. Address 0x15 is status and reads {2'b0, unlocked, violation, mismatch[3:0]}. Groups 0 and 1 are always writable.
- R3: While the space is closed, a write to a data register of group 2 or 3 (0x08–0x0F) or to checksum 0x12/0x13 leaves the register unchanged. From the next cycle on, `violation` reads 1 and stays 1 until reset.
- R4: The space opens only on two key writes that follow each other: `PASSWORD[15:8]` (default 0xC3) and then `PASSWORD[7:0]` (default 0x96). If the second key write carries any other value, the sequence returns to its start. Bytes in the reversed order do not open the space.
- R5: Any key write while the space is open closes it.
- R6: The scrubber checks group 0, then 1, 2, 3, and repeats. One group is judged every `SCAN_PERIOD` cycles. Group 0 is judged at the `SCAN_PERIOD`-th rising edge after reset is released, and group 1 at the 2·`SCAN_PERIOD`-th.
- R7: A judged group whose 8-bit register sum (modulo 256) differs from its stored checksum sets its mismatch bit. A later matching scan does not clear the bit.
- R8: An accepted write to a group's checksum register clears that group's mismatch bit at the same edge. The bit is set again if a later scan still finds a difference.
- R9: If a group receives an accepted write during its scan window, including the cycle in which it is judged, the result of that window is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| unlocked | output | 1 | Guarded space is open |
| mismatch | output | 4 | Per-group checksum mismatch bits |
| violation | output | 1 | Sticky flag for a dropped guarded write |

## Verification
The bench builds the block with `SCAN_PERIOD` = 8 and keeps the default key 0xC396. With the short period a full round of all four groups takes 32 cycles. This makes it cheap to count the exact edge at which group 1 is judged after reset. It also allows a group to be held under writes for several complete windows, to show that those results are discarded, and then left alone so that the difference is reported.

// File: rtl/lockable_csum_regbank.sv
module lockable_csum_regbank #(
  parameter int          SCAN_PERIOD = 1024,
  parameter logic [15:0] PASSWORD    = 16'hC396
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       unlocked,
  output logic [3:0] mismatch,
  output logic       violation
);
  localparam int         CW        = $clog2(SCAN_PERIOD + 1);
  localparam logic [4:0] KEY_ADDR  = 5'h14;
  localparam logic [4:0] STAT_ADDR = 5'h15;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN} key_st_t;

  logic [7:0]    regs [16];
  logic [7:0]    csum [4];
  key_st_t       kst;
  logic [CW-1:0] tick;
  logic [1:0]    grp;
  logic          dirty;

  wire       is_data  = !addr[4];
  wire       is_csum  = addr[4:2] == 3'b100;
  wire [1:0] wgrp     = is_data ? addr[3:2] : addr[1:0];
  wire       guarded  = (is_data || is_csum) && wgrp[1];
  wire       wr_bad   = wr_en && guarded && !unlocked;
  wire       wr_ok    = wr_en && (is_data || is_csum) && !wr_bad;
  wire       key_wr   = wr_en && addr == KEY_ADDR;
  wire       scan_end = tick == CW'(SCAN_PERIOD - 1);
  wire       hit      = wr_ok && wgrp == grp;
  wire [7:0] gsum     = regs[{grp, 2'd0}] + regs[{grp, 2'd1}]
                      + regs[{grp, 2'd2}] + regs[{grp, 2'd3}];

  assign unlocked = kst == KS_OPEN;

  always_comb begin
    rdata = '0;
    if (is_data)               rdata = regs[addr[3:0]];
    else if (is_csum)          rdata = csum[addr[1:0]];
    else if (addr == KEY_ADDR)  rdata = {7'b0, unlocked};
    else if (addr == STAT_ADDR) rdata = {2'b0, unlocked, violation, mismatch};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= '0;
      for (int i = 0; i < 4; i++)  csum[i] <= '0;
    end else if (wr_ok) begin
      if (is_data) regs[addr[3:0]] <= wdata;
      else         csum[addr[1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kst <= KS_IDLE;
    else if (key_wr) begin
      case (kst)
        KS_IDLE: kst <= (wdata == PASSWORD[15:8]) ? KS_HALF : KS_IDLE;
        KS_HALF: kst <= (wdata == PASSWORD[7:0])  ? KS_OPEN : KS_IDLE;
        default: kst <= KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else if (wr_bad) violation <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= '0;
      grp   <= '0;
      dirty <= 1'b0;
    end else if (scan_end) begin
      tick  <= '0;
      grp   <= grp + 2'd1;
      dirty <= 1'b0;
    end else begin
      tick  <= tick + CW'(1);
      dirty <= dirty || hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mismatch <= '0;
    else begin
      for (int g = 0; g < 4; g++) begin
        if (wr_ok && is_csum && addr[1:0] == g[1:0])
          mismatch[g] <= 1'b0;
        else if (scan_end && grp == g[1:0] && !(dirty || hit) && gsum != csum[g])
          mismatch[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockable_csum_regbank_chk.sv
module lockable_csum_regbank_chk #(
  parameter logic [15:0] PASSWORD = 16'hC396
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic       unlocked,
  input logic [3:0] mismatch,
  input logic       violation
);
  wire prot_hit = wr_en && ((!addr[4] && addr[3]) || (addr[4:2] == 3'b100 && addr[1]));
  wire key_hit  = wr_en && addr == 5'h14;

  AST_CLOSED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (!unlocked && prot_hit) |=> violation); // R3
  AST_VIOLATION_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) violation |=> violation); // R3
  AST_OPEN_NEEDS_KEY:     assert property (@(posedge clk) disable iff (!rst_n) $rose(unlocked) |-> $past(key_hit && wdata == PASSWORD[7:0])); // R4
  AST_KEY_RECLOSES:       assert property (@(posedge clk) disable iff (!rst_n) (unlocked && key_hit) |=> !unlocked); // R5
  AST_CSUM_WRITE_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 5'h10) |=> !mismatch[0]); // R8
  AST_MISMATCH_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) $fell(mismatch[0]) |-> $past(wr_en && addr == 5'h10)); // R7
endmodule

bind lockable_csum_regbank lockable_csum_regbank_chk #(.PASSWORD(PASSWORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .unlocked(unlocked), .mismatch(mismatch), .violation(violation)
);

// File: tb/lockable_csum_regbank_tb_top.sv
module lockable_csum_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 8;
  localparam int NV         = 26;
  // {read, addr, write data or expected read data}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 5'h01, 8'h11}, {1'b1, 5'h01, 8'h11},                        // R2 open group
    {1'b0, 5'h09, 8'h22}, {1'b1, 5'h09, 8'h00},                        // R3 dropped
    {1'b0, 5'h14, 8'h96}, {1'b0, 5'h14, 8'hC3}, {1'b0, 5'h09, 8'h33},
    {1'b1, 5'h09, 8'h00}, {1'b1, 5'h14, 8'h00},                        // R4 reversed order
    {1'b0, 5'h14, 8'h00},
    {1'b0, 5'h14, 8'hC3}, {1'b0, 5'h14, 8'h96}, {1'b1, 5'h14, 8'h01},  // R4 opens
    {1'b0, 5'h09, 8'h44}, {1'b1, 5'h09, 8'h44},
    {1'b0, 5'h12, 8'h44}, {1'b1, 5'h12, 8'h44},
    {1'b0, 5'h14, 8'h00}, {1'b1, 5'h14, 8'h00},                        // R5 closes
    {1'b0, 5'h0D, 8'h55}, {1'b1, 5'h0D, 8'h00},
    {1'b0, 5'h14, 8'hC3}, {1'b0, 5'h14, 8'h00}, {1'b1, 5'h14, 8'h00},  // R4 bad second byte
    {1'b0, 5'h0C, 8'h66}, {1'b1, 5'h0C, 8'h00}
  };

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       unlocked, violation;
  logic [3:0] mismatch;
  int         n_run = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lockable_csum_regbank #(.SCAN_PERIOD(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .unlocked(unlocked), .mismatch(mismatch), .violation(violation)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic [4:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = !rd; addr = a; wdata = d;
    #1;
    if (rd) check(req, rdata, d);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    addr = 5'h05;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset rdata",    rdata, 8'h00);
    check("R1 reset unlocked", {7'b0, unlocked}, 8'h00);
    check("R1 reset mismatch", {4'b0, mismatch}, 8'h00);
    check("R1 reset violation", {7'b0, violation}, 8'h00);

    // R6: group 1 judged exactly at edge 2P after release
    @(negedge clk);
    rst_n = 1'b1; wr_en = 1'b1; addr = 5'h04; wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2 * P - 2) @(posedge clk);
    @(negedge clk);
    check("R6 before group1 scan", {4'b0, mismatch}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R6 group1 judged at 2P", {4'b0, mismatch}, 8'h02);

    step(1'b0, 5'h11, 8'h01, "");
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 csum write clears", {4'b0, mismatch}, 8'h00);

    for (int i = 0; i < NV; i++)
      step(VEC[i][13], VEC[i][12:8], VEC[i][7:0], $sformatf("R2/R3/R4/R5 table[%0d]", i));
    idle(1);
    check("R3 violation sticky", {7'b0, violation}, 8'h01);
    check("R5 closed after table", {7'b0, unlocked}, 8'h00);

    idle(4 * P + 4);
    check("R7 group0 mismatch only", {4'b0, mismatch}, 8'h01);
    step(1'b1, 5'h15, 8'h11, "R2 status read");

    step(1'b0, 5'h10, 8'h11, "");
    idle(0);
    check("R8 cleared by csum write", {4'b0, mismatch}, 8'h00);
    idle(4 * P + 4);
    check("R7 matching group stays clear", {4'b0, mismatch}, 8'h00);

    step(1'b0, 5'h10, 8'h12, "");
    idle(4 * P + 4);
    check("R8 set again on next scan", {4'b0, mismatch}, 8'h01);

    step(1'b0, 5'h10, 8'h11, "");
    for (int i = 0; i < 5 * P; i++) step(1'b0, 5'h00, 8'h05, "");
    idle(0);
    check("R9 busy group result discarded", {4'b0, mismatch}, 8'h00);
    idle(4 * P + 4);
    check("R9 reported once quiet", {4'b0, mismatch}, 8'h01);

    @(negedge clk);
    rst_n = 1'b0; addr = 5'h01;
    #1;
    check("R1 mid-run reset data", rdata, 8'h00);
    check("R1 mid-run reset flags", {2'b0, unlocked, violation, mismatch}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule